// File: doc/BRIEF.md
# Dual-Chain Digital Down-Converter with 3-bit Requantizer

This block is the sample pre-processing stage that feeds a bank of correlator channels. It holds two independent chains that share only a clock and a reset. Each chain accepts one stream of input samples. The stream is either a real-valued intermediate-frequency signal or a complex baseband signal, chosen per chain by a format select. In real mode a digital local oscillator moves the signal down to complex baseband. The LO is a 32-bit phase accumulator driving a four-entry quadrant sine/cosine lookup. In complex mode the mixer is bypassed.

After the mixer, a symmetric 16-tap low-pass FIR filters the stream and decimates it by 1, 2, 4 or 8. Each filtered I and Q value is then requantized to three bits: a sign bit and a two-bit magnitude level. The level is measured against a programmable threshold and saturates at the top level. Each decimated sample produces exactly one output-valid pulse.

The format select, LO frequency word, decimation select and threshold are configuration inputs. They are set while the block is in reset and held steady while samples flow.

Top module: `ddc_dual_frontend`

## Requirements
- R1: While reset is asserted and at the first clock after its release, every chain shows out_valid low and both 3-bit output codes equal to zero. The reset clears the filter history, the LO phase and the decimation count.
- R2: With the format select high (complex mode), the mixer passes in_i and in_q, as two's-complement values, straight to the filter's I and Q inputs.
- R3: In real mode the LO phase starts at zero after reset. It advances by the frequency word after every accepted sample. Its two top bits q select the rotation for the current sample, with q=0 giving I=x, Q=0; q=1 giving I=0, Q=-x; q=2 giving I=-x, Q=0; and q=3 giving I=0, Q=x, where x is in_i.
- R4: In real mode in_q has no effect on any output.
- R5: The filter output is the sum over k=0..15 of w(k)·h(k), where h(0) is the newest mixed sample and w(k)=1+min(k,15-k). History entries not yet filled since reset count as zero.
- R6: dec_sel values 0, 1, 2 and 3 give decimation factors D of 1, 2, 4 and 8. A chain emits one output for every D accepted samples. The first output follows the D-th sample after reset.
- R7: An output produced by the sample accepted at clock edge n appears with out_valid high after edge n+3. Cycles without in_valid neither shift the filter nor count toward decimation.
- R8: Each output code has bit 2 as the sign (1 when the filtered value is negative) and bits 1:0 as the level. The level is floor(|y| / T) for the threshold T.
- R9: A level that would exceed 3 saturates at 3.
- R10: The two chains run independently: configuration and samples of one never change the outputs of the other.
- R11: Between out_valid pulses, the output codes hold their last values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | NCH | Per-chain sample strobe |
| in_i | input | NCH*IN_W | Real sample, or in-phase part in complex mode, two's complement |
| in_q | input | NCH*IN_W | Quadrature part in complex mode; ignored in real mode |
| cplx_sel | input | NCH | 1 selects complex baseband input, 0 selects real IF input |
| lo_fcw | input | NCH*PH_W | LO phase increment per accepted sample |
| dec_sel | input | 2*NCH | Decimation select: 0,1,2,3 give 1,2,4,8 |
| mag_thr | input | NCH*ACC_W | Requantizer level step T, nonzero |
| out_valid | output | NCH | One pulse per decimated output sample |
| out_i | output | 3*NCH | Requantized I code {sign, level[1:0]} |
| out_q | output | 3*NCH | Requantized Q code {sign, level[1:0]} |

## Verification
The assertions assume that each chain's decimation select and format select are held constant from reset release until the next reset. They also assume the threshold is nonzero. Under those assumptions, the full-rate rule ties every accepted sample to an output three edges later. The bench changes the configuration only inside a reset window and always uses thresholds of one or more. It sweeps every pairing of format and decimation factor, with the two chains given opposite settings at the same time, and uses irregular valid gaps.

// File: rtl/ddc_pkg.sv
package ddc_pkg;

  // Sum of the triangular FIR weights for an even tap count.
  function automatic int weight_sum(input int ntaps);
    return (ntaps / 2) * (ntaps / 2 + 1);
  endfunction

  // Filter accumulator width: mixed width plus weight growth plus a guard bit.
  function automatic int acc_width(input int in_w, input int ntaps);
    return in_w + 1 + $clog2(weight_sum(ntaps)) + 1;
  endfunction

  // Symmetric triangular weight of tap k.
  function automatic int fir_weight(input int k, input int ntaps);
    int mirror;
    mirror = ntaps - 1 - k;
    return 1 + ((k < mirror) ? k : mirror);
  endfunction

  // Quadrant LO lookup.
  function automatic logic signed [1:0] lo_cos(input logic [1:0] quad);
    case (quad)
      2'd0:    return 2'sb01;
      2'd2:    return 2'sb11;
      default: return 2'sb00;
    endcase
  endfunction

  function automatic logic signed [1:0] lo_sin(input logic [1:0] quad);
    case (quad)
      2'd1:    return 2'sb01;
      2'd3:    return 2'sb11;
      default: return 2'sb00;
    endcase
  endfunction

endpackage

// File: rtl/ddc_mixer.sv
module ddc_mixer #(
  parameter int IN_W = 4,
  parameter int PH_W = 32
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   in_valid,
  input  logic                   cplx_sel,
  input  logic [IN_W-1:0]        in_i,
  input  logic [IN_W-1:0]        in_q,
  input  logic [PH_W-1:0]        lo_fcw,
  output logic                   mix_valid,
  output logic signed [IN_W:0]   mix_i,
  output logic signed [IN_W:0]   mix_q
);

  logic [PH_W-1:0]       phase;
  logic [1:0]            lo_quad;
  logic signed [IN_W:0]  xi, xq, rot_i, rot_q;

  function automatic logic signed [IN_W:0] scale(input logic signed [IN_W:0] x,
                                                 input logic signed [1:0] c);
    if (c == 2'sb01)      return x;
    else if (c == 2'sb11) return -x;
    else                  return '0;
  endfunction

  assign xi      = $signed({in_i[IN_W-1], in_i});
  assign xq      = $signed({in_q[IN_W-1], in_q});
  assign lo_quad = phase[PH_W-1 -: 2];

  always_comb begin
    if (cplx_sel) begin
      rot_i = xi;
      rot_q = xq;
    end else begin
      rot_i = scale(xi, ddc_pkg::lo_cos(lo_quad));
      rot_q = scale(xi, -ddc_pkg::lo_sin(lo_quad));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase     <= '0;
      mix_valid <= 1'b0;
      mix_i     <= '0;
      mix_q     <= '0;
    end else begin
      mix_valid <= in_valid;
      if (in_valid) begin
        phase <= phase + lo_fcw;
        mix_i <= rot_i;
        mix_q <= rot_q;
      end
    end
  end

endmodule

// File: rtl/ddc_fir_decim.sv
module ddc_fir_decim #(
  parameter int D_W   = 5,
  parameter int NTAPS = 16,
  parameter int ACC_W = 13
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     s_valid,
  input  logic signed [D_W-1:0]    s_i,
  input  logic signed [D_W-1:0]    s_q,
  input  logic [1:0]               dec_sel,
  output logic                     fire,
  output logic signed [ACC_W-1:0]  y_i,
  output logic signed [ACC_W-1:0]  y_q
);

  localparam int HALF  = NTAPS / 2;
  localparam int CNT_W = 4;
  localparam int EXT_W = ACC_W - D_W - 1;

  logic signed [D_W-1:0] taps_i [NTAPS];
  logic signed [D_W-1:0] taps_q [NTAPS];
  logic [ACC_W-1:0]      prod_i [HALF];
  logic [ACC_W-1:0]      prod_q [HALF];
  logic [CNT_W-1:0]      phase_cnt;
  logic [CNT_W-1:0]      dec_len;
  logic                  last_of_group;

  assign dec_len       = CNT_W'(1) << dec_sel;
  assign last_of_group = (phase_cnt + 1'b1) == dec_len;

  // Folded symmetric pairs: one weight per pair of mirrored taps.
  for (genvar k = 0; k < HALF; k++) begin : g_pair
    localparam int WK = ddc_pkg::fir_weight(k, NTAPS);
    logic [D_W:0]     pre_i, pre_q;
    logic [ACC_W-1:0] ext_i, ext_q;
    assign pre_i  = {taps_i[k][D_W-1], taps_i[k]} + {taps_i[NTAPS-1-k][D_W-1], taps_i[NTAPS-1-k]};
    assign pre_q  = {taps_q[k][D_W-1], taps_q[k]} + {taps_q[NTAPS-1-k][D_W-1], taps_q[NTAPS-1-k]};
    assign ext_i  = {{EXT_W{pre_i[D_W]}}, pre_i};
    assign ext_q  = {{EXT_W{pre_q[D_W]}}, pre_q};
    assign prod_i[k] = ext_i * ACC_W'(WK);
    assign prod_q[k] = ext_q * ACC_W'(WK);
  end

  always_comb begin
    logic [ACC_W-1:0] acc_i, acc_q;
    acc_i = '0;
    acc_q = '0;
    for (int k = 0; k < HALF; k++) begin
      acc_i = acc_i + prod_i[k];
      acc_q = acc_q + prod_q[k];
    end
    y_i = $signed(acc_i);
    y_q = $signed(acc_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < NTAPS; k++) begin
        taps_i[k] <= '0;
        taps_q[k] <= '0;
      end
      phase_cnt <= '0;
      fire      <= 1'b0;
    end else begin
      fire <= 1'b0;
      if (s_valid) begin
        taps_i[0] <= s_i;
        taps_q[0] <= s_q;
        for (int k = NTAPS - 1; k > 0; k--) begin
          taps_i[k] <= taps_i[k-1];
          taps_q[k] <= taps_q[k-1];
        end
        if (last_of_group) begin
          phase_cnt <= '0;
          fire      <= 1'b1;
        end else begin
          phase_cnt <= phase_cnt + 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/ddc_requant.sv
module ddc_requant #(
  parameter int ACC_W = 13
) (
  input  logic signed [ACC_W-1:0] y,
  input  logic [ACC_W-1:0]        thr,
  output logic [2:0]              code
);

  logic               neg;
  logic [ACC_W-1:0]   y_u, mag;
  logic [ACC_W+1:0]   mag_x, step1, step2, step3;
  logic [1:0]         lvl;

  assign y_u   = y;
  assign neg   = y[ACC_W-1];
  assign mag   = neg ? (~y_u + 1'b1) : y_u;
  assign mag_x = {2'b00, mag};
  assign step1 = {2'b00, thr};
  assign step2 = step1 << 1;
  assign step3 = step1 + step2;

  always_comb begin
    if (mag_x < step1)      lvl = 2'd0;
    else if (mag_x < step2) lvl = 2'd1;
    else if (mag_x < step3) lvl = 2'd2;
    else                    lvl = 2'd3;
  end

  assign code = {neg, lvl};

endmodule

// File: rtl/ddc_chain.sv
module ddc_chain #(
  parameter int IN_W  = 4,
  parameter int PH_W  = 32,
  parameter int NTAPS = 16,
  parameter int ACC_W = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic              cplx_sel,
  input  logic [IN_W-1:0]   in_i,
  input  logic [IN_W-1:0]   in_q,
  input  logic [PH_W-1:0]   lo_fcw,
  input  logic [1:0]        dec_sel,
  input  logic [ACC_W-1:0]  mag_thr,
  output logic              out_valid,
  output logic [2:0]        out_i,
  output logic [2:0]        out_q
);

  logic                    mix_valid;
  logic signed [IN_W:0]    mix_i, mix_q;
  logic                    fir_fire;
  logic signed [ACC_W-1:0] fir_i, fir_q;
  logic [2:0]              code_i, code_q;

  ddc_mixer #(.IN_W(IN_W), .PH_W(PH_W)) u_mix (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .cplx_sel(cplx_sel),
    .in_i(in_i), .in_q(in_q), .lo_fcw(lo_fcw),
    .mix_valid(mix_valid), .mix_i(mix_i), .mix_q(mix_q)
  );

  ddc_fir_decim #(.D_W(IN_W + 1), .NTAPS(NTAPS), .ACC_W(ACC_W)) u_fir (
    .clk(clk), .rst_n(rst_n), .s_valid(mix_valid), .s_i(mix_i), .s_q(mix_q),
    .dec_sel(dec_sel), .fire(fir_fire), .y_i(fir_i), .y_q(fir_q)
  );

  ddc_requant #(.ACC_W(ACC_W)) u_rq_i (.y(fir_i), .thr(mag_thr), .code(code_i));
  ddc_requant #(.ACC_W(ACC_W)) u_rq_q (.y(fir_q), .thr(mag_thr), .code(code_q));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_i     <= '0;
      out_q     <= '0;
    end else begin
      out_valid <= fir_fire;
      if (fir_fire) begin
        out_i <= code_i;
        out_q <= code_q;
      end
    end
  end

endmodule

// File: rtl/ddc_dual_frontend.sv
module ddc_dual_frontend #(
  parameter  int NCH   = 2,
  parameter  int IN_W  = 4,
  parameter  int PH_W  = 32,
  parameter  int NTAPS = 16,
  localparam int ACC_W = ddc_pkg::acc_width(IN_W, NTAPS)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NCH-1:0]        in_valid,
  input  logic [NCH*IN_W-1:0]   in_i,
  input  logic [NCH*IN_W-1:0]   in_q,
  input  logic [NCH-1:0]        cplx_sel,
  input  logic [NCH*PH_W-1:0]   lo_fcw,
  input  logic [2*NCH-1:0]      dec_sel,
  input  logic [NCH*ACC_W-1:0]  mag_thr,
  output logic [NCH-1:0]        out_valid,
  output logic [3*NCH-1:0]      out_i,
  output logic [3*NCH-1:0]      out_q
);

  for (genvar c = 0; c < NCH; c++) begin : g_chain
    ddc_chain #(.IN_W(IN_W), .PH_W(PH_W), .NTAPS(NTAPS), .ACC_W(ACC_W)) u_chain (
      .clk      (clk),
      .rst_n    (rst_n),
      .in_valid (in_valid[c]),
      .cplx_sel (cplx_sel[c]),
      .in_i     (in_i[c*IN_W +: IN_W]),
      .in_q     (in_q[c*IN_W +: IN_W]),
      .lo_fcw   (lo_fcw[c*PH_W +: PH_W]),
      .dec_sel  (dec_sel[2*c +: 2]),
      .mag_thr  (mag_thr[c*ACC_W +: ACC_W]),
      .out_valid(out_valid[c]),
      .out_i    (out_i[3*c +: 3]),
      .out_q    (out_q[3*c +: 3])
    );
  end

endmodule

// File: rtl/ddc_dual_frontend_chk.sv
module ddc_dual_frontend_chk #(
  parameter int NCH = 2
) (
  input logic               clk,
  input logic               rst_n,
  input logic [NCH-1:0]     in_valid,
  input logic [2*NCH-1:0]   dec_sel,
  input logic [NCH-1:0]     out_valid,
  input logic [3*NCH-1:0]   out_i,
  input logic [3*NCH-1:0]   out_q
);

  logic [1:0] since_rst;
  logic       settled;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  since_rst <= 2'd0;
    else if (since_rst != 2'd3)  since_rst <= since_rst + 2'd1;
  end

  assign settled = (since_rst == 2'd3);

  for (genvar c = 0; c < NCH; c++) begin : g_chk
    assert_reset_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (!out_valid[c] && out_i[3*c +: 3] == 3'd0 && out_q[3*c +: 3] == 3'd0));

    assert_valid_source_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (settled && out_valid[c]) |-> $past(in_valid[c], 3));

    assert_full_rate_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (settled && dec_sel[2*c +: 2] == 2'd0 && $past(in_valid[c], 3)) |-> out_valid[c]);

    assert_hold_codes_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !out_valid[c] |-> ($stable(out_i[3*c +: 3]) && $stable(out_q[3*c +: 3])));
  end

endmodule

bind ddc_dual_frontend ddc_dual_frontend_chk #(.NCH(NCH)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .dec_sel(dec_sel),
  .out_valid(out_valid), .out_i(out_i), .out_q(out_q)
);

// File: tb/sim_ddc_dual_frontend.sv
module sim_ddc_dual_frontend;

  localparam int NCH   = 2;
  localparam int IN_W  = 4;
  localparam int PH_W  = 32;
  localparam int NT    = 16;
  localparam int THR_W = 13;   // accumulator width for IN_W=4, 16 taps

  logic                  clk = 1'b0;
  logic                  rst_n = 1'b0;
  logic [NCH-1:0]        in_valid = '0;
  logic [NCH*IN_W-1:0]   in_i = '0;
  logic [NCH*IN_W-1:0]   in_q = '0;
  logic [NCH-1:0]        cplx_sel = '0;
  logic [NCH*PH_W-1:0]   lo_fcw = '0;
  logic [2*NCH-1:0]      dec_sel = '0;
  logic [NCH*THR_W-1:0]  mag_thr = '0;
  logic [NCH-1:0]        out_valid;
  logic [3*NCH-1:0]      out_i, out_q;

  always #2ns clk = ~clk;

  ddc_dual_frontend #(.NCH(NCH), .IN_W(IN_W), .PH_W(PH_W), .NTAPS(NT)) u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_i(in_i), .in_q(in_q),
    .cplx_sel(cplx_sel), .lo_fcw(lo_fcw), .dec_sel(dec_sel), .mag_thr(mag_thr),
    .out_valid(out_valid), .out_i(out_i), .out_q(out_q)
  );

  int total = 0;
  int fails = 0;
  int cyc = 0;
  bit done = 1'b0;

  // reference model state
  int          hist_i [2][NT];
  int          hist_q [2][NT];
  logic [31:0] ph [2];
  logic [31:0] fw [2];
  bit          cx [2];
  int          cnt [2];
  int          dlen [2];
  int          th [2];
  int          last_i [2];
  int          last_q [2];
  string       tag [2];
  int          q0 [$];
  int          q1 [$];
  logic [31:0] lcg = 32'h1234_5678;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int rnd();
    lcg = lcg * 32'd1664525 + 32'd1013904223;
    return int'(lcg[19:16]) - 8;
  endfunction

  function automatic int wgt(input int k);
    return (k <= 7) ? k + 1 : 16 - k;
  endfunction

  function automatic int code_of(input int y, input int t);
    int mag, lv;
    mag = (y < 0) ? -y : y;
    lv  = mag / t;
    if (lv > 3) lv = 3;
    return ((y < 0) ? 4 : 0) + lv;
  endfunction

  // Model one accepted sample of chain c (R2 R3 R4 R5 R6 R8 R9).
  task automatic take(input int c, input int a, input int b);
    int mi, mq, cs, sn, yi, yq, e;
    if (cx[c]) begin
      mi = a; mq = b;
    end else begin
      cs = (ph[c][31:30] == 2'd0) ? 1 : (ph[c][31:30] == 2'd2) ? -1 : 0;
      sn = (ph[c][31:30] == 2'd1) ? 1 : (ph[c][31:30] == 2'd3) ? -1 : 0;
      mi = a * cs;
      mq = -(a * sn);   // b ignored: R4
    end
    ph[c] = ph[c] + fw[c];
    for (int k = NT - 1; k > 0; k--) begin
      hist_i[c][k] = hist_i[c][k-1];
      hist_q[c][k] = hist_q[c][k-1];
    end
    hist_i[c][0] = mi;
    hist_q[c][0] = mq;
    cnt[c]++;
    if (cnt[c] == dlen[c]) begin
      cnt[c] = 0;
      yi = 0; yq = 0;
      for (int k = 0; k < NT; k++) begin
        yi += wgt(k) * hist_i[c][k];
        yq += wgt(k) * hist_q[c][k];
      end
      e = (cyc + 3) * 64 + code_of(yi, th[c]) * 8 + code_of(yq, th[c]);
      if (c == 0) q0.push_back(e); else q1.push_back(e);
    end
  endtask

  task automatic step(input bit v0, input int a0, input int b0,
                      input bit v1, input int a1, input int b1);
    @(negedge clk);
    in_valid = {v1, v0};
    in_i = {4'(a1), 4'(a0)};
    in_q = {4'(b1), 4'(b0)};
    if (v0) take(0, a0, b0);
    if (v1) take(1, a1, b1);
  endtask

  // Output monitor: value, latency (R7) and hold (R11).
  always @(negedge clk) begin
    if (rst_n && !done) begin
      for (int c = 0; c < NCH; c++) begin
        int got, e, n;
        got = cyc * 64 + int'(out_i[3*c +: 3]) * 8 + int'(out_q[3*c +: 3]);
        if (out_valid[c]) begin
          n = (c == 0) ? q0.size() : q1.size();
          if (n == 0) begin
            check(1'b0, {tag[c], " R7 unexpected out_valid"}, got, -1);
          end else begin
            e = (c == 0) ? q0.pop_front() : q1.pop_front();
            check(got == e, {tag[c], " R7 output code/time"}, got, e);
          end
          last_i[c] = int'(out_i[3*c +: 3]);
          last_q[c] = int'(out_q[3*c +: 3]);
        end else begin
          check(int'(out_i[3*c +: 3]) == last_i[c] && int'(out_q[3*c +: 3]) == last_q[c],
                "R11 hold between pulses", int'(out_i[3*c +: 3]) * 8 + int'(out_q[3*c +: 3]),
                last_i[c] * 8 + last_q[c]);
        end
      end
    end
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000 && !done) begin
      done = 1'b1;
      total++;
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 150000);
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  // pat: 0 pseudo-random, 1 impulse, 2 constant extremes
  task automatic run(input string tg, input int pat, input int n, input bit gaps,
                     input bit c0, input logic [31:0] f0, input int d0, input int t0,
                     input bit c1, input logic [31:0] f1, input int d1, input int t1);
    @(posedge clk);
    #1;
    rst_n = 1'b0;
    in_valid = '0;
    cplx_sel = {c1, c0};
    lo_fcw   = {f1, f0};
    dec_sel  = {2'(d1), 2'(d0)};
    mag_thr  = {13'(t1), 13'(t0)};
    cx[0] = c0; cx[1] = c1;
    fw[0] = f0; fw[1] = f1;
    dlen[0] = 1 << d0; dlen[1] = 1 << d1;
    th[0] = t0; th[1] = t1;
    for (int c = 0; c < NCH; c++) begin
      ph[c] = '0; cnt[c] = 0; last_i[c] = 0; last_q[c] = 0;
      tag[c] = {tg, (c == 0) ? " ch0" : " ch1"};
      for (int k = 0; k < NT; k++) begin
        hist_i[c][k] = 0; hist_q[c][k] = 0;
      end
    end
    q0.delete();
    q1.delete();
    repeat (2) @(negedge clk);
    check(out_valid == '0 && out_i == '0 && out_q == '0, "R1 reset state",
          int'(out_valid) + int'(out_i) + int'(out_q), 0);
    rst_n = 1'b1;
    for (int s = 0; s < n; s++) begin
      bit v0, v1;
      int a0, a1;
      v0 = gaps ? ((s % 3) != 2) : 1'b1;
      v1 = gaps ? ((s % 4) != 1) : 1'b1;
      case (pat)
        1:       begin a0 = (s == 0) ? 7 : 0; a1 = (s == 2) ? -8 : 0; end
        2:       begin a0 = -8; a1 = 7; end
        default: begin a0 = rnd(); a1 = rnd(); end
      endcase
      step(v0, a0, rnd(), v1, a1, rnd());
    end
    repeat (8) step(1'b0, 0, 0, 1'b0, 0, 0);
    check(q0.size() == 0, {tg, " R6 chain0 output count"}, q0.size(), 0);
    check(q1.size() == 0, {tg, " R6 chain1 output count"}, q1.size(), 0);
  endtask

  initial begin
    // FIR impulse response, complex bypass, full rate
    run("R2 R5 R8 impulse", 1, 24, 1'b0, 1'b1, 32'h0, 0, 3, 1'b1, 32'h0, 0, 5);
    // random complex streams, two decimation factors
    run("R2 R6 R8 cplx", 0, 60, 1'b0, 1'b1, 32'h0, 0, 40, 1'b1, 32'h0, 1, 25);
    // LO quadrant walk, two samples per quadrant; chain1 half-turn steps
    run("R3 R4 quadrant", 0, 48, 1'b0, 1'b0, 32'h2000_0000, 0, 10, 1'b0, 32'h8000_0000, 0, 12);
    // near-exhaustive sweep over format x decimation, chains opposite (R10)
    for (int d = 0; d < 4; d++) begin
      for (int f = 0; f < 2; f++) begin
        run("R3 R4 R6 R7 R10 sweep", 0, 64, 1'b1,
            f[0], 32'h1234_5678 + 32'(d) * 32'h3000_0001, d, 20 + d * 15,
            ~f[0], 32'h4000_0000, 3 - d, 60);
      end
    end
    // saturation at level 3 with extreme constant inputs
    run("R9 saturation", 2, 40, 1'b0, 1'b0, 32'h0, 2, 1, 1'b1, 32'h0, 3, 1);
    // threshold above any reachable magnitude: level 0, sign kept
    run("R8 large threshold", 0, 40, 1'b1, 1'b1, 32'h0, 0, 4095, 1'b0, 32'h1111_1111, 1, 4095);
    done = 1'b1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

endmodule